// File: doc/BRIEF.md
# Counter Wrap Interrupt Pending Unit

This block holds a bank of event counters and a pending register with one bit per counter. A counter advances by one on each cycle its strobe is high. When it rolls over from all ones to all zeros, the pending bit with the same index is set. Bit 1 is not driven by a counter. It reflects a real-time comparison instead: the real-time value against its compare value. Software reaches the pending register through three CSR addresses, one per privilege level. The supervisor and user addresses return views masked by counter-enable inputs, and a write through a view can only change the bits that view shows. Each counter can also be loaded and read through its own CSR address.

Each pending bit is routed to a privilege level by a two-bit delegation field. A level raises its request when its timer-interrupt enable is set and at least one pending bit delegated to it is visible at that level. When several requests are active, the most privileged one is taken. The block also reports the timer-interrupt cause code of the least privileged level that can see the counters behind the taken request. The CSR port is a plain single-cycle register port: writes land on the clock edge and reads are combinational, so there is no back-pressure.

Top module: `cnt_ovf_irq`

## Requirements
- R1: A strobe on counter i advances it by one on the next edge. A CSR write to address 0xB00+i loads the counter, and a write in the same cycle as a strobe wins. Reading 0xB00+i returns the counter value.
- R2: When counter i (i other than 1) wraps from all ones to zero, pending bit i is set at the same edge, provided bit i is implemented.
- R3: Pending bit 1 reads 1 whenever the real-time value is greater than or equal to its compare value (unsigned), and 0 otherwise. If the hardwire-one option is selected, it always reads 1. Writes never change bit 1.
- R4: Address 0x345 reads the whole pending register. A write there loads every implemented bit except bit 1, so writing a 0 clears the bit.
- R5: If a counter wraps in the same cycle that a write clears its pending bit, the bit ends up set.
- R6: Address 0x145 reads the pending register ANDed with the machine counter-enable mask. A write there only changes bits whose mask bit is 1.
- R7: Address 0x045 shows bit i when all of these hold: user interrupts are implemented, the supervisor counter-enable bit i is set, and either a supervisor mode exists or the machine counter-enable bit i is set. Writes there only change shown bits.
- R8: Bits cleared in the implemented-bit mask read 0 and ignore writes and wraps.
- R9: Delegation field i (bits 2i+1:2i) encodes 0 as user, 1 as supervisor, and 2 or 3 as machine. Each level's request is high when that level's timer enable is set and some pending bit delegated to it is set in that level's view.
- R10: take_valid is high when any request is high. take_lvl gives the most privileged active level, encoded user 0, supervisor 1, machine 3, and is 0 when no request is high.
- R11: take_cause is 4 if any bit behind the taken level is in the user view mask, else 5 if any is in the supervisor mask, else 7. It is 0 when no request is high.
- R12: A CSR address outside 0x345, 0x145, 0x045 and the counter addresses reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_inc | input | NUM_CNT | Per-counter increment strobes |
| rt_now | input | CNT_W | Real-time value |
| rt_cmp | input | CNT_W | Real-time compare value |
| mcen | input | NUM_CNT | Machine counter-enable mask |
| scen | input | NUM_CNT | Supervisor counter-enable mask |
| mtie | input | 1 | Machine timer-interrupt enable |
| stie | input | 1 | Supervisor timer-interrupt enable |
| utie | input | 1 | User timer-interrupt enable |
| dlg_lvl | input | 2*NUM_CNT | Delegation level per pending bit |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | CNT_W | CSR write data |
| csr_rdata | output | CNT_W | CSR read data |
| irq_m | output | 1 | Machine-level request |
| irq_s | output | 1 | Supervisor-level request |
| irq_u | output | 1 | User-level request |
| take_valid | output | 1 | Some request is active |
| take_lvl | output | 2 | Level that takes the interrupt |
| take_cause | output | 4 | Timer cause code reported |

## Verification
The bench drives each counter in turn through its wrap and checks that exactly one new pending bit appears. A wrong index or a missed carry would light the wrong bit or none, and an unimplemented bit that latches would show up as a stray 1. It tests a clear in the same cycle as a wrap, where a design that lets the write win loses the overflow. It also tests the timer compare with the top bit set, where a signed compare reports the wrong result. Supervisor and user views and view-limited writes are swept over many enable patterns, so a mask rule applied to the wrong level or a write that spills into hidden bits changes the value read back. Pseudo-random pending, delegation and enable patterns are checked against an arithmetic model of request, priority and cause, which catches inverted priority or a cause chosen from the wrong mask.

// File: rtl/cip_pkg.sv
package cip_pkg;
  typedef enum logic [1:0] {
    LVL_U = 2'd0,
    LVL_S = 2'd1,
    LVL_R = 2'd2,
    LVL_M = 2'd3
  } lvl_e;

  localparam logic [11:0] ADDR_PEND_M   = 12'h345;
  localparam logic [11:0] ADDR_PEND_S   = 12'h145;
  localparam logic [11:0] ADDR_PEND_U   = 12'h045;
  localparam logic [11:0] ADDR_CNT_BASE = 12'hB00;

  localparam logic [3:0] CAUSE_UT = 4'd4;
  localparam logic [3:0] CAUSE_ST = 4'd5;
  localparam logic [3:0] CAUSE_MT = 4'd7;

  localparam int TIMER_BIT = 1;
endpackage

// File: rtl/cip_counter.sv
module cip_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         wrap
);
  logic [W:0] sum;

  always_comb begin
    sum  = {1'b0, value} + (W+1)'(1);
    wrap = inc & ~wr & sum[W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   value <= '0;
    else if (wr)  value <= wdata;
    else if (inc) value <= sum[W-1:0];
  end

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr) |=> (value == $past(value) + W'(1)));
  p_cnt_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (value == $past(wdata)));
endmodule

// File: rtl/cip_pend.sv
module cip_pend
  import cip_pkg::*;
#(
  parameter int           N         = 32,
  parameter logic [N-1:0] IMPL_MASK = '1,
  parameter bit           TIMER_ONE = 1'b0,
  parameter bit           HAS_S     = 1'b1,
  parameter bit           HAS_U     = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap,
  input  logic         timer_hit,
  input  logic [N-1:0] mcen,
  input  logic [N-1:0] scen,
  input  logic         wr_en,
  input  lvl_e         wr_lvl,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] full,
  output logic [N-1:0] s_view,
  output logic [N-1:0] u_view,
  output logic [N-1:0] s_mask,
  output logic [N-1:0] u_mask
);
  localparam logic [N-1:0] TMR   = N'(1) << TIMER_BIT;
  localparam logic [N-1:0] STORE = IMPL_MASK & ~TMR;

  logic [N-1:0] q, nxt, wmask;

  always_comb begin
    s_mask = mcen;
    u_mask = HAS_U ? (scen & (HAS_S ? {N{1'b1}} : mcen)) : '0;
    case (wr_lvl)
      LVL_S:   wmask = s_mask;
      LVL_U:   wmask = u_mask;
      default: wmask = '1;
    endcase
    nxt = q;
    if (wr_en) nxt = (wr_data & wmask) | (q & ~wmask);
    nxt = (nxt | wrap) & STORE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  always_comb begin
    full   = q | ((TIMER_ONE || timer_hit) ? TMR : '0);
    s_view = full & s_mask;
    u_view = full & u_mask;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    if (STORE[i]) begin : g_live
      p_wrap_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[i] |=> q[i]);
      p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lvl == LVL_M && !wr_data[i] && !wrap[i]) |=> !q[i]);
    end
  end
endmodule

// File: rtl/cip_arb.sv
module cip_arb
  import cip_pkg::*;
#(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   full,
  input  logic [N-1:0]   s_view,
  input  logic [N-1:0]   u_view,
  input  logic [N-1:0]   s_mask,
  input  logic [N-1:0]   u_mask,
  input  logic [2*N-1:0] dlg,
  input  logic           mtie,
  input  logic           stie,
  input  logic           utie,
  output logic           irq_m,
  output logic           irq_s,
  output logic           irq_u,
  output logic           take_valid,
  output lvl_e           take_lvl,
  output logic [3:0]     take_cause
);
  logic [N-1:0] dm, ds, du, src;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      dm[i] = dlg[2*i +: 2] > 2'd1;
      ds[i] = dlg[2*i +: 2] == 2'd1;
      du[i] = dlg[2*i +: 2] == 2'd0;
    end
    irq_m = mtie & |(full & dm);
    irq_s = stie & |(s_view & ds);
    irq_u = utie & |(u_view & du);
    take_valid = irq_m | irq_s | irq_u;
    if (irq_m) begin
      take_lvl = LVL_M; src = full & dm;
    end else if (irq_s) begin
      take_lvl = LVL_S; src = s_view & ds;
    end else if (irq_u) begin
      take_lvl = LVL_U; src = u_view & du;
    end else begin
      take_lvl = LVL_U; src = '0;
    end
    if (!take_valid)          take_cause = 4'd0;
    else if (|(src & u_mask)) take_cause = CAUSE_UT;
    else if (|(src & s_mask)) take_cause = CAUSE_ST;
    else                      take_cause = CAUSE_MT;
  end

  p_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_m |-> (take_valid && take_lvl == LVL_M));
  p_take_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_lvl == LVL_S) |-> stie);
  p_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (take_cause == CAUSE_UT || take_cause == CAUSE_ST || take_cause == CAUSE_MT));
endmodule

// File: rtl/cnt_ovf_irq.sv
module cnt_ovf_irq
  import cip_pkg::*;
#(
  parameter int                 NUM_CNT   = 32,
  parameter int                 CNT_W     = 64,
  parameter logic [NUM_CNT-1:0] IMPL_MASK = '1,
  parameter bit                 TIMER_ONE = 1'b0,
  parameter bit                 HAS_SMODE = 1'b1,
  parameter bit                 HAS_UIRQ  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CNT-1:0]   cnt_inc,
  input  logic [CNT_W-1:0]     rt_now,
  input  logic [CNT_W-1:0]     rt_cmp,
  input  logic [NUM_CNT-1:0]   mcen,
  input  logic [NUM_CNT-1:0]   scen,
  input  logic                 mtie,
  input  logic                 stie,
  input  logic                 utie,
  input  logic [2*NUM_CNT-1:0] dlg_lvl,
  input  logic [11:0]          csr_addr,
  input  logic                 csr_we,
  input  logic [CNT_W-1:0]     csr_wdata,
  output logic [CNT_W-1:0]     csr_rdata,
  output logic                 irq_m,
  output logic                 irq_s,
  output logic                 irq_u,
  output logic                 take_valid,
  output logic [1:0]           take_lvl,
  output logic [3:0]           take_cause
);
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0] wrap, cnt_wr;
  logic [NUM_CNT-1:0] full, s_view, u_view, s_mask, u_mask;
  logic               timer_hit, pend_we;
  lvl_e               pend_lvl, lvl_q;

  assign timer_hit = rt_now >= rt_cmp;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign cnt_wr[i] = csr_we && (csr_addr == ADDR_CNT_BASE + 12'(i));
    cip_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[i]),
      .wr    (cnt_wr[i]),
      .wdata (csr_wdata),
      .value (cnt_val[i]),
      .wrap  (wrap[i])
    );
  end

  always_comb begin
    pend_we  = 1'b0;
    pend_lvl = LVL_M;
    case (csr_addr)
      ADDR_PEND_M: begin pend_we = csr_we; pend_lvl = LVL_M; end
      ADDR_PEND_S: begin pend_we = csr_we; pend_lvl = LVL_S; end
      ADDR_PEND_U: begin pend_we = csr_we; pend_lvl = LVL_U; end
      default: ;
    endcase
  end

  cip_pend #(
    .N(NUM_CNT), .IMPL_MASK(IMPL_MASK), .TIMER_ONE(TIMER_ONE),
    .HAS_S(HAS_SMODE), .HAS_U(HAS_UIRQ)
  ) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap      (wrap),
    .timer_hit (timer_hit),
    .mcen      (mcen),
    .scen      (scen),
    .wr_en     (pend_we),
    .wr_lvl    (pend_lvl),
    .wr_data   (csr_wdata[NUM_CNT-1:0]),
    .full      (full),
    .s_view    (s_view),
    .u_view    (u_view),
    .s_mask    (s_mask),
    .u_mask    (u_mask)
  );

  cip_arb #(.N(NUM_CNT)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .full       (full),
    .s_view     (s_view),
    .u_view     (u_view),
    .s_mask     (s_mask),
    .u_mask     (u_mask),
    .dlg        (dlg_lvl),
    .mtie       (mtie),
    .stie       (stie),
    .utie       (utie),
    .irq_m      (irq_m),
    .irq_s      (irq_s),
    .irq_u      (irq_u),
    .take_valid (take_valid),
    .take_lvl   (lvl_q),
    .take_cause (take_cause)
  );
  assign take_lvl = lvl_q;

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      ADDR_PEND_M: csr_rdata = CNT_W'(full);
      ADDR_PEND_S: csr_rdata = CNT_W'(s_view);
      ADDR_PEND_U: csr_rdata = CNT_W'(u_view);
      default: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (csr_addr == ADDR_CNT_BASE + 12'(i)) csr_rdata = cnt_val[i];
      end
    endcase
  end

  p_timer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == ADDR_PEND_M) |-> (csr_rdata[TIMER_BIT] == (TIMER_ONE || rt_now >= rt_cmp)));
  p_take_en_m_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && take_lvl == 2'd3) |-> mtie);
endmodule

// File: tb/cnt_ovf_irq_tb.sv
`timescale 1ns/1ps
module cnt_ovf_irq_tb;
  localparam logic [31:0] IMPL  = 32'hFFFF_FFF7;
  localparam logic [31:0] STORE = IMPL & ~32'h2;
  localparam logic [11:0] AM = 12'h345, AS = 12'h145, AU = 12'h045;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cnt_inc = '0, mcen = '0, scen = '0;
  logic [63:0] rt_now = '0, rt_cmp = 64'd5, csr_wdata = '0, csr_rdata, dlg_lvl = '0;
  logic        mtie = 0, stie = 0, utie = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic        irq_m, irq_s, irq_u, take_valid;
  logic [1:0]  take_lvl;
  logic [3:0]  take_cause;
  int n_chk = 0, n_bad = 0;
  logic [31:0] expp, seed, rdv;
  logic [63:0] rd;

  always #2 clk = ~clk;

  cnt_ovf_irq #(.IMPL_MASK(IMPL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_inc(cnt_inc), .rt_now(rt_now), .rt_cmp(rt_cmp),
    .mcen(mcen), .scen(scen), .mtie(mtie), .stie(stie), .utie(utie), .dlg_lvl(dlg_lvl),
    .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_m(irq_m), .irq_s(irq_s), .irq_u(irq_u), .take_valid(take_valid),
    .take_lvl(take_lvl), .take_cause(take_cause));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk); csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [63:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    @(negedge clk); cnt_inc = m;
    @(negedge clk); cnt_inc = '0;
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  // model of R9, R10, R11: {irq_m, irq_s, irq_u, valid, lvl[1:0], cause[3:0]}
  function automatic logic [9:0] arb_model(input logic [31:0] p, input logic [63:0] d,
      input logic [31:0] sm, input logic [31:0] um, input logic [2:0] en);
    logic [31:0] dm = '0, ds = '0, du = '0, em, es, eu, c;
    logic im, is, iu;
    logic [1:0] l;
    logic [3:0] cs;
    for (int i = 0; i < 32; i++) begin
      if (d[2*i +: 2] == 2'd0) du[i] = 1'b1;
      else if (d[2*i +: 2] == 2'd1) ds[i] = 1'b1;
      else dm[i] = 1'b1;
    end
    em = p & dm; es = p & sm & ds; eu = p & um & du;
    im = en[2] && em != 0; is = en[1] && es != 0; iu = en[0] && eu != 0;
    if (im) begin l = 2'd3; c = em; end
    else if (is) begin l = 2'd1; c = es; end
    else if (iu) begin l = 2'd0; c = eu; end
    else begin l = 2'd0; c = '0; end
    if (!(im | is | iu)) cs = 4'd0;
    else if ((c & um) != 0) cs = 4'd4;
    else if ((c & sm) != 0) cs = 4'd5;
    else cs = 4'd7;
    return {im, is, iu, im | is | iu, l, cs};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    csr_rd(AM, rd); chk("R4 reset pending", rd, 64'd0);
    csr_rd(12'hB00, rd); chk("R1 reset counter", rd, 64'd0);
    #1; chk("R10 reset take", {61'd0, take_valid, take_lvl}, 64'd0);

    // R1 increment and load
    csr_wr(12'hB07, 64'd100);
    pulse(32'h80); pulse(32'h80); pulse(32'h80);
    csr_rd(12'hB07, rd); chk("R1 count", rd, 64'd103);
    @(negedge clk); csr_addr = 12'hB07; csr_wdata = 64'd50; csr_we = 1; cnt_inc = 32'h80;
    @(negedge clk); csr_we = 0; cnt_inc = '0;
    csr_rd(12'hB07, rd); chk("R1 write wins", rd, 64'd50);
    csr_rd(12'h123, rd); chk("R12 unmapped", rd, 64'd0);

    // R2 / R8 wrap sweep over every counter
    expp = '0;
    for (int i = 0; i < 32; i++) begin
      if (i == 1) continue;
      csr_wr(12'hB00 + 12'(i), '1);
      pulse(32'd1 << i);
      expp |= (32'd1 << i) & STORE;
      csr_rd(12'hB00 + 12'(i), rd); chk("R1 wrap value", rd, 64'd0);
      csr_rd(AM, rd); chk(i == 3 ? "R8 unimpl wrap" : "R2 wrap sets", rd, {32'd0, expp});
    end

    // R4 / R8 writes through machine view
    csr_wr(AM, 64'd0);
    csr_rd(AM, rd); chk("R4 clear", rd, 64'd0);
    csr_wr(AM, 64'hA5A5_5AFE);
    csr_rd(AM, rd); chk("R4 load", rd, {32'd0, 32'hA5A5_5AFE & STORE});
    csr_wr(AM, 64'h8);
    csr_rd(AM, rd); chk("R8 write ignored", rd, 64'd0);

    // R5 clear and wrap in same cycle
    csr_wr(12'hB04, '1);
    @(negedge clk); csr_addr = AM; csr_wdata = 64'd0; csr_we = 1; cnt_inc = 32'h10;
    @(negedge clk); csr_we = 0; cnt_inc = '0;
    csr_rd(AM, rd); chk("R5 overflow wins", rd, 64'h10);

    // R3 timer compare
    csr_wr(AM, 64'd0);
    rt_now = 64'd10; rt_cmp = 64'd10; csr_rd(AM, rd); chk("R3 equal", rd, 64'h2);
    rt_now = 64'd9; csr_rd(AM, rd); chk("R3 below", rd, 64'h0);
    rt_now = 64'h8000_0000_0000_0000; rt_cmp = 64'd1; csr_rd(AM, rd); chk("R3 unsigned", rd, 64'h2);
    csr_wr(AM, 64'h0);
    csr_rd(AM, rd); chk("R3 write ignored", rd, 64'h2);
    rt_now = 64'd0; rt_cmp = 64'd5;

    // R6 / R7 views
    seed = 32'h1234_5678;
    csr_wr(AM, '1);
    for (int k = 0; k < 24; k++) begin
      seed = xs(seed); mcen = seed;
      seed = xs(seed); scen = (k == 0) ? '1 : seed;
      if (k == 0) mcen = '0;
      csr_rd(AS, rd); chk("R6 supervisor view", rd, {32'd0, STORE & mcen});
      csr_rd(AU, rd); chk("R7 user view", rd, {32'd0, STORE & scen});
    end
    mcen = 32'h0000_FFFF;
    csr_wr(AS, 64'd0);
    csr_rd(AM, rd); chk("R6 masked write", rd, {32'd0, STORE & 32'hFFFF_0000});
    scen = 32'hFF00_0000;
    csr_wr(AU, 64'd0);
    csr_rd(AM, rd); chk("R7 masked write", rd, {32'd0, STORE & 32'h00FF_0000});

    // R9 / R10 / R11 directed: machine and user bits together
    csr_wr(AM, 64'h11);
    dlg_lvl = 64'h3; mcen = '1; scen = '1; mtie = 1; stie = 1; utie = 1; #1;
    chk("R10 machine first", {54'd0, irq_m, irq_s, irq_u, take_valid, take_lvl, take_cause},
        {54'd0, arb_model(32'h11, 64'h3, '1, '1, 3'b111)});
    chk("R10 level 3", {62'd0, take_lvl}, 64'd3);
    chk("R11 cause user", {60'd0, take_cause}, 64'd4);

    // R9 / R10 / R11 pseudo-random sweep
    for (int k = 0; k < 60; k++) begin
      logic [9:0] e;
      logic [31:0] p;
      seed = xs(seed); p = seed & STORE;
      csr_wr(AM, {32'd0, p});
      seed = xs(seed); dlg_lvl[31:0] = seed;
      seed = xs(seed); dlg_lvl[63:32] = seed;
      seed = xs(seed); mcen = seed;
      seed = xs(seed); scen = seed;
      seed = xs(seed); {mtie, stie, utie} = seed[2:0];
      #1;
      e = arb_model(p, dlg_lvl, mcen, scen, {mtie, stie, utie});
      chk("R9 requests", {61'd0, irq_m, irq_s, irq_u}, {61'd0, e[9:7]});
      chk("R10 take", {61'd0, take_valid, take_lvl}, {61'd0, e[6:4]});
      chk("R11 cause", {60'd0, take_cause}, {60'd0, e[3:0]});
    end

    rdv = '0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule